// File: doc/BRIEF.md
# Mode-Configurable Serial Baud Tick Generator

This block turns a system clock into the bit-rate timing of a serial port that runs either asynchronously or with a shared synchronous clock. Software loads a divisor value n one byte at a time. Three static mode inputs then pick the overall divide ratio: a synchronous select, a wide-divisor enable and a high-speed select. The ratio is a prescale factor of 64, 16 or 4 multiplied by (n+1).

Two outputs are produced. The first is a one-clock bit tick at the bit rate. The second is an oversample tick that the receiver uses to place its three majority-vote samples inside each bit. A write to either divisor byte restarts the timing at once, so a new rate needs no wait for the old period to run out. A change on any mode input restarts it as well.

Top module: `baud_tick_gen`

## Requirements
- R1: Reset clears both divisor bytes to 0 and holds `bit_tick` and `os_tick` low. With no writes and all mode inputs low after reset, the bit period is 64 clocks.
- R2: With `sync_mode`=0, `wide_en`=0 and `fast_sel`=0, the bit period is 64×(n+1) clocks, where n is the low divisor byte alone.
- R3: With `sync_mode`=0 and exactly one of `wide_en` and `fast_sel` set to 1, the bit period is 16×(n+1) clocks.
- R4: With `sync_mode`=0, `wide_en`=1 and `fast_sel`=1, the bit period is 4×(n+1) clocks.
- R5: With `sync_mode`=1, the bit period is 4×(n+1) clocks whatever the value of `fast_sel`.
- R6: With `wide_en`=1, n is {high byte, low byte}. With `wide_en`=0 the high byte has no effect on the period, but it stays stored and is used once `wide_en` is set.
- R7: A write to either divisor byte (`div_lo_wr` or `div_hi_wr` high at a clock edge) clears the count. The next `bit_tick` comes exactly P×(n_new+1) clocks after that edge, and no tick of either kind comes in the cycle after the write.
- R8: A change on any of `sync_mode`, `wide_en` or `fast_sel` seen at a clock edge restarts the count. The next `bit_tick` comes exactly P×(n+1) clocks after that edge, using the new P.
- R9: `bit_tick` is high for exactly one clock per period.
- R10: `os_tick` fires 16 times per bit in the ÷64 and ÷16 modes and 4 times per bit in the ÷4 modes, spaced evenly. Its last pulse in each bit coincides with `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_lo_wr | input | 1 | Write strobe for the low divisor byte |
| div_hi_wr | input | 1 | Write strobe for the high divisor byte |
| div_wdata | input | 8 | Divisor byte to be written |
| sync_mode | input | 1 | 1 = synchronous mode (fixed ÷4 prescale) |
| wide_en | input | 1 | 1 = 16-bit divisor {high, low} |
| fast_sel | input | 1 | High-speed select, used in asynchronous mode only |
| bit_tick | output | 1 | One-clock pulse per bit period |
| os_tick | output | 1 | Oversample pulse for receiver sampling |

## Verification
The hardest cases to reach are restarts that arrive in the middle of a period: a divisor write or a mode flip that lands while the count and the prescale phase are both non-zero. The stimulus waits a set number of cycles past a bit tick before it writes or toggles a mode bit. It then times the next tick from that exact edge. The wide-divisor case parks a non-zero high byte while the block is in 8-bit mode, confirms the period ignores it, and only then sets the wide enable. A behavioural elapsed-time model checks both outputs on every clock across all of these transitions.

// File: rtl/baud_pkg.sv
// Shared types for the baud tick generator.
package baud_pkg;
    // Prescale factor applied after the (n+1) divider.
    typedef enum logic [1:0] {
        PS_DIV64 = 2'd0,
        PS_DIV16 = 2'd1,
        PS_DIV4  = 2'd2
    } ps_sel_e;

    // Mode inputs grouped for change detection.
    typedef struct packed {
        logic sync_mode;
        logic wide_en;
        logic fast_sel;
    } baud_mode_t;
endpackage

// File: rtl/baud_mode_decode.sv
// Maps the three mode inputs onto a prescale selection.
// Assumes the inputs are static between restarts; purely combinational.
module baud_mode_decode
    import baud_pkg::*;
(
    input  baud_mode_t mode,
    output ps_sel_e    ps_sel
);
    // Sync forces /4; async picks by how many of wide/fast are set.
    always_comb begin
        if (mode.sync_mode)
            ps_sel = PS_DIV4;
        else if (mode.wide_en && mode.fast_sel)
            ps_sel = PS_DIV4;
        else if (mode.wide_en ^ mode.fast_sel)
            ps_sel = PS_DIV16;
        else
            ps_sel = PS_DIV64;
    end
endmodule

// File: rtl/baud_div_reg.sv
// Holds the two divisor bytes and presents the active divisor n.
// Assumes one-cycle write strobes; the high byte is kept even in narrow mode.
module baud_div_reg #(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wide_en,
    output logic [DIV_W-1:0]  div_n
);
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Capture divisor bytes on their strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_wr) lo_q <= wdata;
            if (hi_wr) hi_q <= wdata;
        end
    end

    // Active divisor: the full pair when wide, else the low byte alone.
    always_comb begin
        div_n = wide_en ? {hi_q, lo_q} : {{BYTE_W{1'b0}}, lo_q};
    end
endmodule

// File: rtl/baud_period_cnt.sv
// Counts 0..n and flags the wrap, giving one pulse every (n+1) clocks.
// Assumes n only changes together with a clear, so the count never passes n.
module baud_period_cnt #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] div_n,
    output logic             wrap
);
    logic [DIV_W-1:0] cnt_q;

    // A wrap is the cycle where the count sits at n and no restart is pending.
    always_comb begin
        wrap = !clear && (cnt_q == div_n);
    end

    // Advance the count, returning to zero on a wrap or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (cnt_q == div_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/baud_prescale.sv
// Divides the (n+1) wrap pulses by 64, 16 or 4 and registers both ticks.
// Assumes sel is constant between clears.
module baud_prescale
    import baud_pkg::*;
#(
    parameter int MAX_DIV   = 64,
    parameter int OS_PER_BIT = 16,
    localparam int PS_W     = $clog2(MAX_DIV)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    wrap,
    input  ps_sel_e sel,
    output logic    bit_tick,
    output logic    os_tick
);
    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] last;
    logic [PS_W-1:0] os_mask;

    // Terminal phase and oversample mask for the chosen factor.
    always_comb begin
        unique case (sel)
            PS_DIV64: begin
                last    = PS_W'(MAX_DIV - 1);
                os_mask = PS_W'(MAX_DIV / OS_PER_BIT - 1);
            end
            PS_DIV16: begin
                last    = PS_W'(MAX_DIV / 4 - 1);
                os_mask = '0;
            end
            default: begin
                last    = PS_W'(MAX_DIV / 16 - 1);
                os_mask = '0;
            end
        endcase
    end

    // Step the prescale phase on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            ps_q <= '0;
        else if (wrap)
            ps_q <= (ps_q == last) ? '0 : ps_q + 1'b1;
    end

    // Register the bit and oversample pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bit_tick <= 1'b0;
            os_tick  <= 1'b0;
        end else begin
            bit_tick <= wrap && (ps_q == last);
            os_tick  <= wrap && ((ps_q & os_mask) == os_mask);
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Top: divisor storage, mode decode, restart detection, divider, prescaler.
// Assumes mode inputs are synchronous to clk; any change restarts timing.
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_lo_wr,
    input  logic              div_hi_wr,
    input  logic [BYTE_W-1:0] div_wdata,
    input  logic              sync_mode,
    input  logic              wide_en,
    input  logic              fast_sel,
    output logic              bit_tick,
    output logic              os_tick
);
    baud_mode_t       mode_now;
    baud_mode_t       mode_q;
    ps_sel_e          ps_sel;
    logic [DIV_W-1:0] div_n;
    logic             restart;
    logic             wrap;

    // Group the mode inputs.
    always_comb begin
        mode_now = '{sync_mode: sync_mode, wide_en: wide_en, fast_sel: fast_sel};
    end

    // Remember the last mode to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else
            mode_q <= mode_now;
    end

    // Restart on any divisor write or mode change.
    always_comb begin
        restart = div_lo_wr || div_hi_wr || (mode_now != mode_q);
    end

    baud_mode_decode u_decode (
        .mode   (mode_now),
        .ps_sel (ps_sel)
    );

    baud_div_reg #(.BYTE_W(BYTE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_wr   (div_lo_wr),
        .hi_wr   (div_hi_wr),
        .wdata   (div_wdata),
        .wide_en (wide_en),
        .div_n   (div_n)
    );

    baud_period_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .div_n (div_n),
        .wrap  (wrap)
    );

    baud_prescale u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .wrap     (wrap),
        .sel      (ps_sel),
        .bit_tick (bit_tick),
        .os_tick  (os_tick)
    );
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Protocol checks on the tick generator's ports, attached by bind.
module baud_tick_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic div_lo_wr,
    input logic div_hi_wr,
    input logic sync_mode,
    input logic wide_en,
    input logic fast_sel,
    input logic bit_tick,
    input logic os_tick
);
    // R9: a bit tick never lasts two cycles.
    p_bit_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R10: every bit tick carries an oversample tick.
    p_bit_has_os_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    // R7: no tick of either kind in the cycle after a divisor write.
    p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_lo_wr || div_hi_wr) |=> (!bit_tick && !os_tick));

    // R8: no bit tick in the cycle after a mode change.
    p_mode_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({sync_mode, wide_en, fast_sel}) |=> !bit_tick);

    // R1: outputs are low while reset is applied.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!bit_tick && !os_tick));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_lo_wr (div_lo_wr),
    .div_hi_wr (div_hi_wr),
    .sync_mode (sync_mode),
    .wide_en   (wide_en),
    .fast_sel  (fast_sel),
    .bit_tick  (bit_tick),
    .os_tick   (os_tick)
);

// File: tb/tb_baud_tick_gen.sv
// Bench: elapsed-time reference model compared every clock, plus period checks.
module tb_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_lo_wr = 1'b0;
    logic       div_hi_wr = 1'b0;
    logic [7:0] div_wdata = 8'h00;
    logic       sync_mode = 1'b0;
    logic       wide_en = 1'b0;
    logic       fast_sel = 1'b0;
    logic       bit_tick;
    logic       os_tick;

    int    n_checks = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Reference model state.
    int m_lo = 0, m_hi = 0, m_elapsed = 0, m_prev_mode = 0;
    bit m_bit = 1'b0, m_os = 1'b0;

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .div_lo_wr(div_lo_wr), .div_hi_wr(div_hi_wr),
        .div_wdata(div_wdata), .sync_mode(sync_mode), .wide_en(wide_en),
        .fast_sel(fast_sel), .bit_tick(bit_tick), .os_tick(os_tick)
    );

    always #2 clk = ~clk;

    function automatic int pre_factor(bit s, bit w, bit f);
        if (s || (w && f)) return 4;
        if (w ^ f) return 16;
        return 64;
    endfunction

    // Model: time since last restart; ticks at multiples of the periods.
    always @(posedge clk) begin
        int mode_now, n, p, os_step;
        mode_now = {sync_mode, wide_en, fast_sel};
        if (!rst_n) begin
            m_lo = 0; m_hi = 0; m_elapsed = 0; m_prev_mode = 0;
            m_bit = 0; m_os = 0;
        end else begin
            if (div_lo_wr || div_hi_wr || mode_now != m_prev_mode) begin
                m_elapsed = 0; m_bit = 0; m_os = 0;
            end else begin
                n = wide_en ? (m_hi * 256 + m_lo) : m_lo;
                p = pre_factor(sync_mode, wide_en, fast_sel);
                os_step = (p == 64) ? 4 : 1;
                m_elapsed++;
                m_bit = (m_elapsed % (p * (n + 1))) == 0;
                m_os  = (m_elapsed % (os_step * (n + 1))) == 0;
            end
            if (div_lo_wr) m_lo = div_wdata;
            if (div_hi_wr) m_hi = div_wdata;
            m_prev_mode = mode_now;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(cur_req, "bit_tick vs model", bit_tick, m_bit);
            check(cur_req, "os_tick vs model", os_tick, m_os);
        end
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected <= 150000 cycles", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic wr_byte(bit hi, int val);
        @(negedge clk);
        div_wdata = val[7:0];
        if (hi) div_hi_wr = 1'b1; else div_lo_wr = 1'b1;
        @(negedge clk);
        div_lo_wr = 1'b0;
        div_hi_wr = 1'b0;
    endtask

    task automatic set_mode(bit s, bit w, bit f);
        @(negedge clk);
        sync_mode = s; wide_en = w; fast_sel = f;
    endtask

    // Time one full bit period and count oversample ticks inside it.
    task automatic measure(string req, int exp_period, int exp_os);
        int m = 0, os_cnt = 0;
        while (!bit_tick) @(negedge clk);
        do begin
            @(negedge clk);
            m++;
            if (os_tick) os_cnt++;
            if (bit_tick) check(req, "bit_tick width next cycle", 0, 0);
        end while (!bit_tick && m < 30000);
        check(req, "bit period", m, exp_period);
        check(req, "os ticks per bit", os_cnt, exp_os);
        @(negedge clk);
        check(req, "bit_tick one cycle wide (R9)", bit_tick, 0);
    endtask

    // Count clocks from a restart edge to the next bit tick.
    task automatic time_to_tick(string req, int exp);
        int m = 0;
        check(req, "no tick right after restart", bit_tick, 0);
        while (!bit_tick && m < 30000) begin
            @(negedge clk);
            m++;
        end
        check(req, "restart-to-tick clocks", m, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "bit_tick in reset", bit_tick, 0);
        check("R1", "os_tick in reset", os_tick, 0);
        rst_n = 1'b1;
        measure("R1", 64, 16);

        cur_req = "R2";
        wr_byte(1'b1, 5);
        wr_byte(1'b0, 3);
        measure("R2", 256, 16);             // high byte ignored in 8-bit mode (R6)

        cur_req = "R3";
        set_mode(0, 0, 1);
        measure("R3", 64, 16);
        wr_byte(1'b1, 1);
        set_mode(0, 1, 0);
        cur_req = "R6";
        measure("R6", 16 * 260, 16);         // R3 and R6: n = 0x0103

        cur_req = "R4";
        set_mode(0, 1, 1);
        measure("R4", 4 * 260, 4);

        cur_req = "R5";
        set_mode(1, 0, 0);
        measure("R5", 16, 4);
        set_mode(1, 0, 1);
        measure("R5", 16, 4);                // fast_sel ignored in sync mode
        set_mode(1, 1, 0);
        measure("R5", 4 * 260, 4);

        cur_req = "R7";
        set_mode(0, 0, 0);
        wr_byte(1'b0, 25);
        measure("R7", 1664, 16);
        while (!bit_tick) @(negedge clk);
        repeat (700) @(negedge clk);
        div_wdata = 8'd9; div_lo_wr = 1'b1;
        @(negedge clk);
        div_lo_wr = 1'b0;
        time_to_tick("R7", 640);
        repeat (100) @(negedge clk);
        div_wdata = 8'd2; div_hi_wr = 1'b1;  // high write restarts even in 8-bit mode
        @(negedge clk);
        div_hi_wr = 1'b0;
        time_to_tick("R7", 640);

        cur_req = "R8";
        repeat (300) @(negedge clk);
        fast_sel = 1'b1;
        @(negedge clk);
        time_to_tick("R8", 160);
        repeat (50) @(negedge clk);
        sync_mode = 1'b1;
        @(negedge clk);
        time_to_tick("R8", 40);
        measure("R10", 40, 4);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule